// File: doc/BRIEF.md
# Converter serial register port

This block is the device-side serial port of a data converter. A host shifts an 8-bit command byte into the port on its serial clock. The command picks one of four internal registers and says whether the next transfer reads it or writes it. The selected register is then shifted in or out, MSB first. The port has one output line, and that line does two jobs. During a read it carries register bits. Between transfers it carries an active-low data-ready flag, which the host can use as an interrupt.

A conversion engine, outside this block, sends a one-cycle done strobe together with a 24-bit result. It also sends a warning strobe a short time before it will replace the result. The port stores the result and pulls the ready flag low. The flag goes high again in two cases: when the host completes a full read of the result, or when the warning strobe arrives and the result has not been read. The mode and filter registers are plain storage, and their contents are brought out for the conversion engine.

The serial pins are oversampled on the system clock. The serial clock may stop and restart at any point without losing the bit position. The chip select may also be tied low permanently, so that a three-wire host can frame transfers only by the sequence of command bytes.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, status reads 0x8C, mode reads 0x02 (also on `mode_cfg`), filter reads 0x04 (also on `filt_cfg`), and data reads 0x000000. With no result pending, `dout_rdy` is 1 while chip select is low.
- R2: Each transaction begins with a command byte. It is sampled on rising SCLK edges, MSB first. Bit 3 is the direction (1 = read) and bits 5:4 select the register: 00 status on read, 01 mode, 10 filter, 11 data. A write command with select 00 touches no register, and the next byte is again a command.
- R3: A read drives the register MSB first. Each bit changes after an SCLK falling edge and is held through the following rising edge. Status, mode and filter are 8 bits long; data is 24 bits long.
- R4: A write of 8 bits to mode or filter updates the stored value and its output port. A write to the data register takes 24 bits and changes nothing.
- R5: A `conv_done` strobe stores `conv_data` as the data register and makes the ready flag 0. The flag appears on `dout_rdy` between transfers and as status bit 7.
- R6: An `upd_warn` strobe while a result is unread sets the ready flag back to 1.
- R7: Completing all 24 bits of a data read sets the ready flag to 1, both on the pin and in status bit 7.
- R8: A `conv_done` that arrives during a data read is dropped. The data register keeps its value and the ready flag is not lowered.
- R9: While `cs_n` is high, `dout_en` is 0, and the ready flag still follows conversion events.
- R10: Raising `cs_n` during a transfer aborts it. Nothing is written, a partial data read does not clear the ready flag, and the next byte is a command.
- R11: Pauses of any length in SCLK, between or inside bytes, do not change the outcome of a transfer.
- R12: With `cs_n` held low, back-to-back transactions are framed by the command sequence alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host, idles high |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data from host |
| dout_rdy | output | 1 | Serial read data, or the active-low ready flag between transfers |
| dout_en | output | 1 | Output enable for `dout_rdy` (0 = high impedance) |
| conv_done | input | 1 | One-cycle strobe: new result on `conv_data` |
| conv_data | input | 24 | Conversion result |
| upd_warn | input | 1 | One-cycle strobe: result about to be replaced |
| mode_cfg | output | 8 | Stored mode register |
| filt_cfg | output | 8 | Stored filter register |

## Verification
The assertions take several things for granted about the inputs. SCLK holds each level for at least three system clocks, so that every edge is seen once after synchronisation. DIN changes only while SCLK is low. `conv_done` and `upd_warn` are single-cycle strobes. The bench holds each SCLK half period for four system clocks and moves DIN together with the falling edge. It fires the conversion strobes from the system clock, including one strobe in the middle of a data read.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

  // register select field of the command byte
  typedef enum logic [1:0] {
    SEL_CS   = 2'b00,
    SEL_MODE = 2'b01,
    SEL_FILT = 2'b10,
    SEL_DATA = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_e;

  // bit positions inside the command byte (decoded by the frame FSM)
  localparam int CMD_RW_BIT  = 3;
  localparam int CMD_SEL_MSB = 5;

endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stg_q[s] <= d;
      end else begin
        stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/adc_sif_frame.sv
module adc_sif_frame
  import adc_sif_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              din_s,
  input  logic [DATA_W-1:0] peek_word,
  output sel_e              peek_sel,
  output logic              wr_en,
  output sel_e              wr_sel,
  output logic [REG_W-1:0]  wr_byte,
  output logic              rd_done,
  output logic              data_busy,
  output logic              rd_active,
  output logic              sdo_bit
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  phase_e             ph_q, ph_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [DATA_W-1:0]  sr_q, sr_d;
  sel_e               sel_q, sel_d;
  logic               bit_q, bit_d;
  logic               sclk_q;
  logic               rise, fall;
  logic [CNT_W-1:0]   last_idx;

  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  // the byte in flight is {sr_q[6:0], din_s}: field bit k sits at sr_q[k-1]
  assign peek_sel = sel_e'(sr_q[CMD_SEL_MSB-1 -: 2]);
  assign last_idx = (sel_q == SEL_DATA) ? CNT_W'(DATA_W - 1) : CNT_W'(REG_W - 1);

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    sr_d    = sr_q;
    sel_d   = sel_q;
    bit_d   = bit_q;
    wr_en   = 1'b0;
    rd_done = 1'b0;
    wr_sel  = sel_q;
    wr_byte = {sr_q[REG_W-2:0], din_s};
    if (cs_n_s) begin
      ph_d  = PH_CMD;
      cnt_d = '0;
    end else if (rise) begin
      unique case (ph_q)
        PH_CMD: begin
          sr_d  = {sr_q[DATA_W-2:0], din_s};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(REG_W - 1)) begin
            cnt_d = '0;
            sel_d = peek_sel;
            if (sr_q[CMD_RW_BIT-1]) begin
              ph_d = PH_RD;
              sr_d = peek_word;
            end else if (peek_sel != SEL_CS) begin
              ph_d = PH_WR;
            end
          end
        end
        PH_WR: begin
          sr_d  = {sr_q[DATA_W-2:0], din_s};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == last_idx) begin
            ph_d  = PH_CMD;
            cnt_d = '0;
            wr_en = (sel_q != SEL_DATA);
          end
        end
        PH_RD: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == last_idx) begin
            ph_d    = PH_CMD;
            cnt_d   = '0;
            rd_done = (sel_q == SEL_DATA);
          end
        end
        default: ph_d = PH_CMD;
      endcase
    end else if (fall && ph_q == PH_RD) begin
      bit_d = sr_q[DATA_W-1];
      sr_d  = {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_CMD;
      cnt_q  <= '0;
      sr_q   <= '0;
      sel_q  <= SEL_CS;
      bit_q  <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sr_q   <= sr_d;
      sel_q  <= sel_d;
      bit_q  <= bit_d;
      sclk_q <= sclk_s;
    end
  end

  assign rd_active = (ph_q == PH_RD);
  assign data_busy = rd_active && (sel_q == SEL_DATA);
  assign sdo_bit   = bit_q;

  // R10: a deselect returns the frame to the command phase at bit zero
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (ph_q == PH_CMD) && (cnt_q == '0));

  // R3: the read bit moves only on a falling serial edge
  a_r3_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall && ph_q == PH_RD) |=> $stable(bit_q));

  // R2: the eighth command bit with the direction bit set opens a read
  a_r2_read_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_s && rise && ph_q == PH_CMD && cnt_q == CNT_W'(REG_W - 1) && sr_q[CMD_RW_BIT-1])
    |=> (ph_q == PH_RD));

  // R3: the bit index stays inside the longest register
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(DATA_W));

endmodule

// File: rtl/adc_sif_regs.sv
module adc_sif_regs
  import adc_sif_pkg::*;
#(
  parameter int               DATA_W   = 24,
  parameter int               REG_W    = 8,
  parameter logic [REG_W-2:0] STAT_LOW = 7'h0C,
  parameter logic [REG_W-1:0] MODE_RST = 8'h02,
  parameter logic [REG_W-1:0] FILT_RST = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sel_e              wr_sel,
  input  logic [REG_W-1:0]  wr_byte,
  input  logic              rd_done,
  input  logic              data_busy,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              upd_warn,
  input  sel_e              peek_sel,
  output logic [DATA_W-1:0] peek_word,
  output logic              rdy_n,
  output logic [REG_W-1:0]  mode_q,
  output logic [REG_W-1:0]  filt_q
);

  localparam int PAD_W = DATA_W - REG_W;

  logic [DATA_W-1:0] data_q, data_d;
  logic [REG_W-1:0]  mode_d, filt_d;
  logic              rdy_d;
  logic              accept;

  assign accept = conv_done & ~data_busy;

  always_comb begin
    data_d = data_q;
    mode_d = mode_q;
    filt_d = filt_q;
    rdy_d  = rdy_n;
    if (accept) data_d = conv_data;
    if (wr_en && wr_sel == SEL_MODE) mode_d = wr_byte;
    if (wr_en && wr_sel == SEL_FILT) filt_d = wr_byte;
    if (rd_done)       rdy_d = 1'b1;
    else if (accept)   rdy_d = 1'b0;
    else if (upd_warn) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mode_q <= MODE_RST;
      filt_q <= FILT_RST;
      rdy_n  <= 1'b1;
    end else begin
      data_q <= data_d;
      mode_q <= mode_d;
      filt_q <= filt_d;
      rdy_n  <= rdy_d;
    end
  end

  always_comb begin
    unique case (peek_sel)
      SEL_CS:   peek_word = {rdy_n, STAT_LOW, {PAD_W{1'b0}}};
      SEL_MODE: peek_word = {mode_q, {PAD_W{1'b0}}};
      SEL_FILT: peek_word = {filt_q, {PAD_W{1'b0}}};
      default:  peek_word = data_q;
    endcase
  end

  // R5: an accepted result is stored and lowers the flag
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !data_busy) |=> (!rdy_n && data_q == $past(conv_data)));

  // R7: a finished data read raises the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> rdy_n);

  // R8: the result is frozen while it is being shifted out
  a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    data_busy |=> $stable(data_q));

  // R6: the warning strobe raises the flag unless a new result lands
  a_r6_warn: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_warn && !(conv_done && !data_busy)) |=> rdy_n);

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sif_pkg::*;
#(
  parameter int               DATA_W      = 24,
  parameter int               REG_W       = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [REG_W-2:0] STAT_LOW    = 7'h0C,
  parameter logic [REG_W-1:0] MODE_RST    = 8'h02,
  parameter logic [REG_W-1:0] FILT_RST    = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout_rdy,
  output logic              dout_en,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              upd_warn,
  output logic [REG_W-1:0]  mode_cfg,
  output logic [REG_W-1:0]  filt_cfg
);

  logic [2:0]        pins_s;
  logic              sclk_s, cs_n_s, din_s;
  logic [DATA_W-1:0] peek_word;
  sel_e              peek_sel, wr_sel;
  logic              wr_en, rd_done, data_busy, rd_active, sdo_bit, rdy_n;
  logic [REG_W-1:0]  wr_byte;

  adc_sif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({sclk, cs_n, din}),
    .q   (pins_s)
  );
  assign {sclk_s, cs_n_s, din_s} = pins_s;

  adc_sif_frame #(.DATA_W(DATA_W), .REG_W(REG_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .cs_n_s    (cs_n_s),
    .din_s     (din_s),
    .peek_word (peek_word),
    .peek_sel  (peek_sel),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_byte   (wr_byte),
    .rd_done   (rd_done),
    .data_busy (data_busy),
    .rd_active (rd_active),
    .sdo_bit   (sdo_bit)
  );

  adc_sif_regs #(
    .DATA_W(DATA_W), .REG_W(REG_W), .STAT_LOW(STAT_LOW),
    .MODE_RST(MODE_RST), .FILT_RST(FILT_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_byte   (wr_byte),
    .rd_done   (rd_done),
    .data_busy (data_busy),
    .conv_done (conv_done),
    .conv_data (conv_data),
    .upd_warn  (upd_warn),
    .peek_sel  (peek_sel),
    .peek_word (peek_word),
    .rdy_n     (rdy_n),
    .mode_q    (mode_cfg),
    .filt_q    (filt_cfg)
  );

  assign dout_rdy = rd_active ? sdo_bit : rdy_n;
  assign dout_en  = ~cs_n;

  // R9: deselected means the output is released
  a_r9_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dout_en);

endmodule

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;

  localparam int HP = 4;

  typedef struct {
    logic [23:0] val;
    int          w;
    string       tag;
  } exp_t;

  logic        clk, rst_n, sclk, cs_n, din, conv_done, upd_warn;
  logic [23:0] conv_data;
  logic        dout_rdy, dout_en;
  logic [7:0]  mode_cfg, filt_cfg;

  int    n_vec  = 0;
  int    n_fail = 0;
  exp_t  sb_q[$];
  bit    mon_on = 0;

  adc_serial_port dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout_rdy(dout_rdy), .dout_en(dout_en), .conv_done(conv_done),
    .conv_data(conv_data), .upd_warn(upd_warn),
    .mode_cfg(mode_cfg), .filt_cfg(filt_cfg)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic [23:0] act, input logic [23:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: assembles read bits on rising SCLK and compares with the scoreboard
  initial begin
    logic [23:0] acc;
    int          nb;
    acc = '0;
    nb  = 0;
    forever begin
      @(posedge sclk);
      if (mon_on) begin
        acc = {acc[22:0], dout_rdy};
        nb++;
        if (nb == sb_q[0].w) begin
          exp_t e;
          e = sb_q.pop_front();
          chk(acc & ((24'h1 << e.w) - 24'h1), e.val, e.tag);
          nb     = 0;
          acc    = '0;
          mon_on = 0;
        end
      end
    end
  end

  task automatic pulse(input logic b, input int gap);
    @(negedge clk);
    sclk = 1'b0;
    din  = b;
    repeat (HP) @(negedge clk);
    sclk = 1'b1;
    repeat (HP + gap) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] v, input int w, input int gap);
    for (int i = w - 1; i >= 0; i--) pulse(v[i], gap);
  endtask

  function automatic logic [7:0] cmd(input logic [1:0] sel, input logic rd);
    return {2'b00, sel, rd, 3'b000};
  endfunction

  // driver: pushes the expected word, then clocks the read out
  task automatic rd_reg(input logic [1:0] sel, input logic [23:0] exp, input string tag,
                        input int gap);
    exp_t e;
    e.val = exp;
    e.w   = (sel == 2'b11) ? 24 : 8;
    e.tag = tag;
    send({16'h0, cmd(sel, 1'b1)}, 8, gap);
    sb_q.push_back(e);
    mon_on = 1;
    send(24'h0, e.w, gap);
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [23:0] v);
    send({16'h0, cmd(sel, 1'b0)}, 8, 0);
    send(v, (sel == 2'b11) ? 24 : 8, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic conv(input logic [23:0] v);
    @(negedge clk);
    conv_data = v;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b1; cs_n = 1'b1; din = 1'b0;
    conv_done = 1'b0; upd_warn = 1'b0; conv_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R9: deselected output released, reset contents
    chk({23'h0, dout_en}, 24'h0, "R9 dout_en while deselected");
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    chk({23'h0, dout_rdy}, 24'h1, "R1 idle ready flag");
    chk({16'h0, mode_cfg}, 24'h02, "R1 mode_cfg reset");
    chk({16'h0, filt_cfg}, 24'h04, "R1 filt_cfg reset");
    rd_reg(2'b00, 24'h8C, "R1 R2 status reset", 0);
    rd_reg(2'b01, 24'h02, "R1 R3 mode reset", 0);
    rd_reg(2'b10, 24'h04, "R1 R3 filter reset", 0);
    rd_reg(2'b11, 24'h000000, "R1 R3 data reset", 0);

    // R4: writes
    wr_reg(2'b01, 24'hA5);
    chk({16'h0, mode_cfg}, 24'hA5, "R4 mode_cfg after write");
    rd_reg(2'b01, 24'hA5, "R4 mode readback", 0);
    wr_reg(2'b10, 24'h3C);
    chk({16'h0, filt_cfg}, 24'h3C, "R4 filt_cfg after write");
    wr_reg(2'b11, 24'hFFFFFF);
    rd_reg(2'b11, 24'h000000, "R4 data write ignored", 0);
    // R2: write command with select 00 is a lone byte, next byte is a command
    send({16'h0, cmd(2'b00, 1'b0)}, 8, 0);
    rd_reg(2'b10, 24'h3C, "R2 comm write then filter read", 0);

    // R5 / R7
    conv(24'h123456);
    chk({23'h0, dout_rdy}, 24'h0, "R5 flag low after result");
    rd_reg(2'b00, 24'h0C, "R5 status bit7 low", 0);
    rd_reg(2'b11, 24'h123456, "R5 R3 data value", 0);
    chk({23'h0, dout_rdy}, 24'h1, "R7 pin high after data read");
    rd_reg(2'b00, 24'h8C, "R7 status bit7 high", 0);

    // R6
    conv(24'hABCDEF);
    chk({23'h0, dout_rdy}, 24'h0, "R6 flag low before warning");
    @(negedge clk); upd_warn = 1'b1; @(negedge clk); upd_warn = 1'b0;
    repeat (3) @(negedge clk);
    chk({23'h0, dout_rdy}, 24'h1, "R6 flag high after warning");
    rd_reg(2'b11, 24'hABCDEF, "R6 result kept", 0);

    // R8: result during a data read
    conv(24'h111111);
    fork
      rd_reg(2'b11, 24'h111111, "R8 read not disturbed", 0);
      begin
        repeat (120) @(negedge clk);
        conv(24'h222222);
      end
    join
    chk({23'h0, dout_rdy}, 24'h1, "R8 flag not lowered");
    rd_reg(2'b11, 24'h111111, "R8 data kept", 0);

    // R9: flag tracks while deselected
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    conv(24'h0F0F0F);
    chk({23'h0, dout_en}, 24'h0, "R9 released while deselected");
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    chk({23'h0, dout_rdy}, 24'h0, "R9 flag low after reselect");

    // R10: aborted data read and aborted write
    send({16'h0, cmd(2'b11, 1'b1)}, 8, 0);
    send(24'h0, 5, 0);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    chk({23'h0, dout_rdy}, 24'h0, "R10 partial read keeps flag");
    send({16'h0, cmd(2'b01, 1'b0)}, 8, 0);
    send(24'hF, 4, 0);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    chk({16'h0, mode_cfg}, 24'hA5, "R10 aborted write no effect");
    rd_reg(2'b01, 24'hA5, "R10 next byte is a command", 0);

    // R11: long pauses inside a transfer
    rd_reg(2'b10, 24'h3C, "R11 gapped read", 40);
    send({16'h0, cmd(2'b01, 1'b0)}, 8, 25);
    send(24'h66, 8, 25);
    repeat (4) @(negedge clk);
    chk({16'h0, mode_cfg}, 24'h66, "R11 gapped write");

    // R12: three-wire, back-to-back without deselect
    wr_reg(2'b01, 24'h5A);
    rd_reg(2'b01, 24'h5A, "R12 back-to-back mode", 0);
    rd_reg(2'b00, 24'h0C, "R12 back-to-back status", 0);
    rd_reg(2'b11, 24'h0F0F0F, "R12 back-to-back data", 0);
    chk({23'h0, dout_rdy}, 24'h1, "R12 flag high after data read");

    if (sb_q.size() != 0) begin
      n_vec++;
      n_fail++;
      $display("FAIL scoreboard actual=%0d pending expected=0", sb_q.size());
    end
    finish_run();
  end

endmodule